// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Port

This block is one 32-pin general-purpose I/O port with a small register bank on a synchronous write/read bus. It keeps a drive value and a drive enable for each pin and samples the pin levels through a two-stage synchronizer. Each pin can also raise an interrupt. A pin takes part only when its source-select bit is set. Its sense bits choose edge or level detection and the active sense. A detected event sets a sticky status bit. Software can clear that bit, and only by one kind of access.

Every register has four word addresses. They write the register, set bits, clear bits or toggle bits. A read of any of the four returns the register value. The interrupt outputs are combinational reductions of status AND enable. When the split-line option is on, the lower half of the pins drives one line and the upper half drives the other. The bus has no back-pressure. A write completes in the cycle it is presented, and read data follows the address combinationally. The block has no streaming data path, so there is no valid/ready pair.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every register reads 0 and pad_out, pad_oe, irq_main and irq_high are 0.
- R2: Register index is bus_addr[6:4]: 0 drive value, 1 sampled input, 2 drive enable, 3 source select, 4 interrupt enable, 5 sense type, 6 sense polarity, 7 status. bus_addr[3:2] selects the access: 0 write, 1 OR-in, 2 AND-out (clear), 3 XOR (toggle). Accesses with bus_addr[1:0] != 0 or bus_addr[7] = 1 do nothing, and reads from them return 0. A read of any alias returns the register value.
- R3: pad_out equals the drive-value register and pad_oe equals the drive-enable register. A 1 in the drive-enable register makes the pin drive.
- R4: A read of index 1 returns pad_in as it was two rising edges earlier (two-flop synchronizer). Writes to index 1 have no effect.
- R5: With sense type 0 (edge), the status bit sets on a synchronized 0-to-1 change when polarity is 1, and on a 1-to-0 change when polarity is 0. Status sets on the third rising edge after the pad changes. A change in the other direction has no effect.
- R6: With sense type 1 (level), the status bit sets on every cycle in which the synchronized pin equals the polarity bit. The bit stays set after the pin stops matching, until it is cleared.
- R7: A pin whose source-select bit is 0 never sets its status bit.
- R8: A status bit clears only when a 1 is written in its position to address 0x78. Plain write, OR-in and toggle writes to status, and 0 bits written to 0x78, leave status unchanged.
- R9: If a clear and a new event for the same pin fall in the same cycle, the status bit stays set.
- R10: With the split-line option on (the default), irq_main is the OR of status AND enable over pins 0 to 15, and irq_high is the same OR over pins 16 to 31. With the option off, irq_main covers all pins and irq_high is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write access |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | 32 | Pin levels from the pads |
| pad_out | output | 32 | Drive values to the pads |
| pad_oe | output | 32 | Drive enables to the pads |
| irq_main | output | 1 | Interrupt line for the lower pins, or for all pins |
| irq_high | output | 1 | Interrupt line for the upper pins |

## Verification
The assertions assume that pad_in is held stable at 0 during reset. This lets the synchronizer history after reset match the pad history that the input-tracking property compares against. The stimulus drives pad_in and the bus only on falling edges, so each value is stable across the rising edge that captures it. When pins are switched to level mode, the sense bits are programmed before the source-select bit. This keeps an unintended low-level match from setting status in the middle of a configuration.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_SET    = 2'd1,
    OP_CLEAR  = 2'd2,
    OP_TOGGLE = 2'd3
  } alias_op_e;

  localparam int RI_DOUT = 0;
  localparam int RI_DIN  = 1;
  localparam int RI_OE   = 2;
  localparam int RI_SRC  = 3;
  localparam int RI_IEN  = 4;
  localparam int RI_LVL  = 5;
  localparam int RI_POL  = 6;
  localparam int RI_STAT = 7;
endpackage

// File: rtl/gpio_alias_reg.sv
`timescale 1ns/1ps
module gpio_alias_reg import gpio_pkg::*; #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  alias_op_e    op,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (we) begin
      case (op)
        OP_WRITE:  q <= wdata;
        OP_SET:    q <= q | wdata;
        OP_CLEAR:  q <= q & ~wdata;
        default:   q <= q ^ wdata;
      endcase
    end
  end
endmodule

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] src,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] clr,
  output logic [W-1:0] stat
);
  logic [W-1:0] prev;
  logic [W-1:0] match;
  logic [W-1:0] changed_to_match;
  logic [W-1:0] event_now;

  // pin equals its selected sense value
  assign match            = ~(level ^ pol);
  assign changed_to_match = match & (level ^ prev);
  assign event_now        = src & ((lvl & match) | (~lvl & changed_to_match));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= '0;
      stat <= '0;
    end else begin
      prev <= level;
      // new event wins over a clear in the same cycle
      stat <= (stat & ~clr) | event_now;
    end
  end
endmodule

// File: rtl/gpio_irq_port.sv
`timescale 1ns/1ps
module gpio_irq_port import gpio_pkg::*; #(
  parameter int NPINS     = 32,
  parameter int AW        = 8,
  parameter bit HIGH_LINE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             irq_main,
  output logic             irq_high
);
  localparam int OP_LSB  = 2;
  localparam int IDX_LSB = 4;
  localparam int IDXW    = 3;
  localparam int NREGS   = 1 << IDXW;
  localparam int HALF    = NPINS / 2;

  logic [IDXW-1:0]  idx;
  alias_op_e        op;
  logic             hit;
  logic             wr;
  logic [NPINS-1:0] regs [NREGS];
  logic [NPINS-1:0] din_sync;
  logic [NPINS-1:0] stat;
  logic [NPINS-1:0] clr_mask;
  logic [NPINS-1:0] src;
  logic [NPINS-1:0] ien;
  logic [NPINS-1:0] pending;

  assign idx = bus_addr[IDX_LSB +: IDXW];
  assign op  = alias_op_e'(bus_addr[OP_LSB +: 2]);
  assign hit = (bus_addr[OP_LSB-1:0] == '0) &&
               ((bus_addr >> (IDX_LSB + IDXW)) == '0);
  assign wr  = bus_valid && bus_write && hit;

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    if (r == RI_DIN) begin : g_din
      assign regs[r] = din_sync;
    end else if (r == RI_STAT) begin : g_stat
      assign regs[r] = stat;
    end else begin : g_cfg
      gpio_alias_reg #(.W(NPINS)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr && (idx == IDXW'(r))),
        .op    (op),
        .wdata (bus_wdata),
        .q     (regs[r])
      );
    end
  end

  assign clr_mask = (wr && idx == IDXW'(RI_STAT) && op == OP_CLEAR) ? bus_wdata : '0;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (din_sync)
  );

  assign src = regs[RI_SRC];
  assign ien = regs[RI_IEN];

  gpio_irq_detect #(.W(NPINS)) u_det (
    .clk   (clk),
    .rst_n (rst_n),
    .level (din_sync),
    .src   (src),
    .lvl   (regs[RI_LVL]),
    .pol   (regs[RI_POL]),
    .clr   (clr_mask),
    .stat  (stat)
  );

  assign pad_out   = regs[RI_DOUT];
  assign pad_oe    = regs[RI_OE];
  assign bus_rdata = hit ? regs[idx] : '0;
  assign pending   = stat & ien;

  if (HIGH_LINE) begin : g_split
    assign irq_main = |pending[HALF-1:0];
    assign irq_high = |pending[NPINS-1:HALF];
  end else begin : g_single
    assign irq_main = |pending;
    assign irq_high = 1'b0;
  end
endmodule

// File: rtl/gpio_irq_port_chk.sv
`timescale 1ns/1ps
module gpio_irq_port_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_valid,
  input logic             bus_write,
  input logic [AW-1:0]    bus_addr,
  input logic [NPINS-1:0] bus_rdata,
  input logic [NPINS-1:0] pad_in,
  input logic [NPINS-1:0] pad_out,
  input logic             irq_main,
  input logic             irq_high,
  input logic [NPINS-1:0] stat,
  input logic [NPINS-1:0] src,
  input logic [NPINS-1:0] ien
);
  localparam logic [AW-1:0] STAT_CLR = AW'((7 << 4) | (2 << 2));

  logic [1:0] age;
  logic       clr_wr;
  logic       dout_wr;
  logic       din_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assign clr_wr  = bus_valid && bus_write && (bus_addr == STAT_CLR);
  assign dout_wr = bus_valid && bus_write && ((bus_addr >> 4) == '0);
  assign din_rd  = ((bus_addr >> 4) == 1) && (bus_addr[1:0] == 2'b00);

  AST_STAT_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((stat & $past(stat)) == $past(stat))); // R8

  AST_STAT_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0) |-> ((stat & ~$past(stat) & ~$past(src)) == '0)); // R7

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> (!irq_main && !irq_high)); // R10

  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_wr |=> $stable(pad_out)); // R3

  AST_DIN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && din_rd) |-> (bus_rdata == $past(pad_in, 2))); // R4
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .pad_in    (pad_in),
  .pad_out   (pad_out),
  .irq_main  (irq_main),
  .irq_high  (irq_high),
  .stat      (stat),
  .src       (src),
  .ien       (ien)
);

// File: tb/gpio_irq_port_test.sv
`timescale 1ns/1ps
module gpio_irq_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq_main, irq_high;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_port uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_main(irq_main), .irq_high(irq_high)
  );

  // reference model state
  logic [31:0] m_dout = '0, m_oe = '0, m_src = '0, m_ien = '0;
  logic [31:0] m_lvl = '0, m_pol = '0, m_stat = '0;
  logic [31:0] hist[$] = '{32'h0, 32'h0, 32'h0}; // [0] first stage, [1] sampled, [2] previous

  function automatic logic [31:0] apply(logic [31:0] old, int o, logic [31:0] wd);
    case (o)
      0: return wd;
      1: return old | wd;
      2: return old & ~wd;
      default: return old ^ wd;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    if (a[1:0] != 2'b00 || a[7]) return 32'h0;
    case (int'(a[6:4]))
      0: return m_dout;
      1: return hist[1];
      2: return m_oe;
      3: return m_src;
      4: return m_ien;
      5: return m_lvl;
      6: return m_pol;
      default: return m_stat;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dout = '0; m_oe = '0; m_src = '0; m_ien = '0;
      m_lvl = '0; m_pol = '0; m_stat = '0;
      hist = '{32'h0, 32'h0, 32'h0};
    end else begin
      logic [31:0] ev;
      logic [31:0] clr;
      ev  = '0;
      clr = '0;
      for (int i = 0; i < 32; i++) begin
        bit s, p;
        s = hist[1][i];
        p = hist[2][i];
        if (m_src[i]) begin
          if (m_lvl[i]) ev[i] = (s == m_pol[i]);
          else          ev[i] = m_pol[i] ? (s && !p) : (!s && p);
        end
      end
      if (bus_valid && bus_write && bus_addr[1:0] == 2'b00 && !bus_addr[7]) begin
        int ri, o;
        ri = int'(bus_addr[6:4]);
        o  = int'(bus_addr[3:2]);
        case (ri)
          0: m_dout = apply(m_dout, o, bus_wdata);
          2: m_oe   = apply(m_oe,   o, bus_wdata);
          3: m_src  = apply(m_src,  o, bus_wdata);
          4: m_ien  = apply(m_ien,  o, bus_wdata);
          5: m_lvl  = apply(m_lvl,  o, bus_wdata);
          6: m_pol  = apply(m_pol,  o, bus_wdata);
          7: if (o == 2) clr = bus_wdata;
          default: ;
        endcase
      end
      m_stat = (m_stat & ~clr) | ev;
      hist.push_front(pad_in);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (!done) begin
      string tag;
      tag = (bus_addr[6:4] == 3'd1) ? "R4" : (bus_addr[6:4] == 3'd7) ? "R8" : "R2";
      chk("R3 pad_out", pad_out, m_dout);
      chk("R3 pad_oe", pad_oe, m_oe);
      chk("R10 irq_main", {31'h0, irq_main}, {31'h0, |(m_stat & m_ien & 32'h0000FFFF)});
      chk("R10 irq_high", {31'h0, irq_high}, {31'h0, |(m_stat & m_ien & 32'hFFFF0000)});
      chk(tag, bus_rdata, exp_rd(bus_addr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #2;
    chk(req, bus_rdata, exp);
  endtask

  task automatic pad(input logic [31:0] v);
    @(negedge clk);
    pad_in = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state
    for (int i = 0; i < 8; i++) rd("R1", 8'(i * 16), 32'h0);
    chk("R1 outputs", {pad_out[0], pad_oe[0], irq_main, irq_high, 28'h0} | (pad_out | pad_oe), 32'h0);

    // R2: alias operations on the drive-value register, R3 at the pads
    wr(8'h00, 32'hA5A5_0F0F); rd("R2 write", 8'h00, 32'hA5A5_0F0F);
    wr(8'h04, 32'h0000_F000); rd("R2 set", 8'h04, 32'hA5A5_FF0F);
    wr(8'h08, 32'hA500_0000); rd("R2 clear", 8'h08, 32'h00A5_FF0F);
    wr(8'h0C, 32'hFFFF_0000); rd("R2 toggle", 8'h0C, 32'hFF5A_FF0F);
    chk("R3 drive", pad_out, 32'hFF5A_FF0F);
    wr(8'h20, 32'h0000_FFFF);
    chk("R3 enable", pad_oe, 32'h0000_FFFF);
    wr(8'h01, 32'hFFFF_FFFF); rd("R2 misaligned", 8'h00, 32'hFF5A_FF0F);
    wr(8'h80, 32'hFFFF_FFFF); rd("R2 out of range", 8'h80, 32'h0);

    // R4: synchronizer latency and read-only input register
    pad(32'h1234_5678);
    rd("R4 one edge", 8'h10, 32'h0);
    rd("R4 two edges", 8'h10, 32'h1234_5678);
    wr(8'h10, 32'hFFFF_FFFF); rd("R4 write ignored", 8'h10, 32'h1234_5678);
    pad(32'h0); idle(4);

    // R5: rising edge on pin 3, with latency
    wr(8'h64, 32'h8); wr(8'h44, 32'h8); wr(8'h34, 32'h8);
    pad(32'h8);
    rd("R5 edge 1", 8'h70, 32'h0);
    rd("R5 edge 2", 8'h70, 32'h0);
    rd("R5 edge 3", 8'h70, 32'h8);
    chk("R10 main line", {31'h0, irq_main}, 32'h1);
    chk("R10 high line idle", {31'h0, irq_high}, 32'h0);
    wr(8'h78, 32'h8);
    pad(32'h0); idle(4);
    rd("R5 wrong direction", 8'h70, 32'h0);

    // R5: falling edge on pin 20, upper line
    wr(8'h34, 32'h0010_0000); wr(8'h44, 32'h0010_0000);
    pad(32'h0010_0000); idle(4);
    rd("R5 rise ignored in falling mode", 8'h70, 32'h0);
    pad(32'h0); idle(4);
    rd("R5 falling", 8'h70, 32'h0010_0000);
    chk("R10 high line", {31'h0, irq_high}, 32'h1);
    chk("R10 main line idle", {31'h0, irq_main}, 32'h0);

    // R7: unselected pin 6 never latches
    wr(8'h64, 32'h40);
    pad(32'h40); idle(3); pad(32'h0); idle(4);
    rd("R7 unselected", 8'h70, 32'h0010_0000);

    // R8: only 1s written to the clear alias clear status
    wr(8'h70, 32'h0);         rd("R8 plain write", 8'h70, 32'h0010_0000);
    wr(8'h74, 32'hFFFF_FFFF); rd("R8 set alias", 8'h70, 32'h0010_0000);
    wr(8'h7C, 32'hFFFF_FFFF); rd("R8 toggle alias", 8'h70, 32'h0010_0000);
    wr(8'h78, 32'h0);         rd("R8 zero clear", 8'h70, 32'h0010_0000);
    wr(8'h78, 32'h0010_0000); rd("R8 clear", 8'h70, 32'h0);

    // R6 and R9: high level on pin 5
    wr(8'h54, 32'h20); wr(8'h64, 32'h20); wr(8'h34, 32'h20);
    pad(32'h20); idle(4);
    rd("R6 high level", 8'h70, 32'h20);
    wr(8'h78, 32'h20);
    rd("R9 clear loses to event", 8'h70, 32'h20);
    pad(32'h0); idle(4);
    rd("R6 sticky", 8'h70, 32'h20);
    wr(8'h78, 32'h20); idle(2);
    rd("R6 cleared after release", 8'h70, 32'h0);

    // R6: low level on pin 7, sense programmed before select
    wr(8'h54, 32'h80); wr(8'h34, 32'h80); idle(1);
    rd("R6 low level", 8'h70, 32'h80);

    idle(2);
    finish_run();
  end
endmodule